// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block owns the divider and multiplier settings of an external PLL and changes them on request. A request carries a target output rate and the rate of the clock feeding the PLL. The sequencer searches a parameter-defined table of supported rates for an exact match. When it finds one, it drives the register writes that hold the PLL in reset, load the input divider N, load the multiplier M and load the output shift OD. It then watches the PLL's lock indication for a bounded number of cycles. If lock never comes, it programs the settings that were in effect before the request back into the PLL and reports the failure.

A separate combinational port rounds any rate up to the nearest supported table rate. An always-valid readback gives the nominal rate produced by the fields currently applied. When the table is configured with zero entries, the PLL is treated as read-only. Set requests are refused, the rounding port reports no result, and only the readback works.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A requester keeps `req_valid`, `req_rate` and `parent_rate` steady until the handshake completes. `parent_rate` stays steady until `done` has pulsed. Completion has no back-pressure: `done` is a single-cycle pulse, and `status` holds the outcome until the next completion.

Top module: `pll_reprog_seq`

## Requirements
- R1: `cur_rate` always equals ((`parent_rate` × M) / N) >> OD, computed from the fields last written to the PLL and truncated to the rate width. It reads 0 when N is 0. After reset the fields are RST_N, RST_M and RST_OD.
- R2: A request whose `parent_rate` or `req_rate` is zero writes nothing. `done` pulses in the cycle after acceptance, with `status` = 01 (invalid).
- R3: A request whose rate equals no entry among the first TBL_COUNT table entries writes nothing and completes with `status` = 01. When entries repeat a rate, the lowest-indexed entry is used.
- R4: A valid request produces four writes in consecutive cycles, in this order:
  - register select 0 (N register), with bit 29 (reset) set and the previous N in bits [NW-1:0];
  - select 0, with bit 29 clear and the new N;
  - select 1 (M register), with the new M in bits [MW-1:0];
  - select 2 (OD register), with the new OD in bits [ODW-1:0].
- R5: After the OD write, the lock input is checked once per cycle, for at most LOCK_POLLS checks. When lock is seen on the first programming pass, `done` pulses in the next cycle with `status` = 00.
- R6: If LOCK_POLLS checks pass without lock, the next cycle starts a second four-write sequence that carries the settings held before the request. The request then completes with `status` = 10, whatever lock does during that second pass. The applied fields end up equal to the prior ones.
- R7: `rnd_rate` is the first table entry whose rate is at or above `rnd_req`. If no entry qualifies, it is entry 0. `rnd_ok` is 1 whenever the table is non-empty.
- R8: With TBL_COUNT = 0, every set request completes with `status` = 01 and no writes, `rnd_ok` = 0 and `rnd_rate` = 0, and `cur_rate` still follows R1.
- R9: `req_ready` is high exactly when idle. `done` lasts one cycle. `status` is never 11. `req_ready` is high again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Set request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_rate | input | RW | Target rate of the request |
| parent_rate | input | RW | Rate of the PLL's input clock |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 invalid, 10 timeout with settings restored |
| rnd_req | input | RW | Rate to round |
| rnd_rate | output | RW | Rounded supported rate |
| rnd_ok | output | 1 | Rounding result valid (table non-empty) |
| cur_rate | output | RW | Nominal rate of the applied fields |
| wr_en | output | 1 | PLL register write strobe |
| wr_sel | output | 2 | Register select: 0 N, 1 M, 2 OD |
| wr_data | output | 32 | Register write data |
| pll_lock | input | 1 | Lock indication from the PLL |

## Verification
The assertions assume three things about the inputs. `parent_rate` and `req_rate` are held steady through a handshake. The table holds consistent N, M and OD values. `pll_lock` is driven from reset onward. The stimulus keeps to these assumptions. It changes `parent_rate` only while the sequencer is idle, and it drives lock from a behavioural PLL model. That model drops lock on every reset write and regains it a few cycles after the OD write, or never when a request is marked to fail. Random requests mix table rates, arbitrary rates and zero values. Directed cases cover the rounding boundaries and a read-only instance.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int DATA_W  = 32;
  localparam int RST_BIT = 29;

  localparam logic [1:0] SEL_N  = 2'd0;
  localparam logic [1:0] SEL_M  = 2'd1;
  localparam logic [1:0] SEL_OD = 2'd2;

  localparam logic [1:0] STAT_OK      = 2'd0;
  localparam logic [1:0] STAT_INVALID = 2'd1;
  localparam logic [1:0] STAT_TIMEOUT = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_N, S_M, S_OD, S_POLL, S_FIN
  } seq_state_e;
endpackage

// File: rtl/pll_rate_lookup.sv
module pll_rate_lookup #(
  parameter int RW = 16,
  parameter int NW = 5,
  parameter int MW = 9,
  parameter int ODW = 2,
  parameter int DEPTH = 4,
  parameter int COUNT = 4,
  parameter logic [DEPTH*RW-1:0]  TBL_RATE = '0,
  parameter logic [DEPTH*NW-1:0]  TBL_N    = '0,
  parameter logic [DEPTH*MW-1:0]  TBL_M    = '0,
  parameter logic [DEPTH*ODW-1:0] TBL_OD   = '0
) (
  input  logic [RW-1:0]  set_rate,
  output logic           hit,
  output logic [NW-1:0]  hit_n,
  output logic [MW-1:0]  hit_m,
  output logic [ODW-1:0] hit_od,
  input  logic [RW-1:0]  rnd_req,
  output logic [RW-1:0]  rnd_rate,
  output logic           rnd_ok
);
  // exact match, scanned downward so the lowest index wins
  always_comb begin
    hit    = 1'b0;
    hit_n  = '0;
    hit_m  = '0;
    hit_od = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (i < COUNT && TBL_RATE[i*RW +: RW] == set_rate) begin
        hit    = 1'b1;
        hit_n  = TBL_N[i*NW +: NW];
        hit_m  = TBL_M[i*MW +: MW];
        hit_od = TBL_OD[i*ODW +: ODW];
      end
    end
  end

  // round up to first entry at or above the request, else entry 0
  always_comb begin
    logic found;
    found    = 1'b0;
    rnd_ok   = (COUNT > 0);
    rnd_rate = (COUNT > 0) ? TBL_RATE[0 +: RW] : '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && i < COUNT && rnd_req <= TBL_RATE[i*RW +: RW]) begin
        rnd_rate = TBL_RATE[i*RW +: RW];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int RW = 16,
  parameter int NW = 5,
  parameter int MW = 9,
  parameter int ODW = 2
) (
  input  logic [RW-1:0]  parent_rate,
  input  logic [NW-1:0]  n,
  input  logic [MW-1:0]  m,
  input  logic [ODW-1:0] od,
  output logic [RW-1:0]  rate
);
  localparam int PW = RW + MW;

  logic [PW-1:0] prod;
  logic [PW-1:0] quo;

  always_comb begin
    prod = {{MW{1'b0}}, parent_rate} * {{RW{1'b0}}, m};
    quo  = (n == '0) ? '0 : prod / {{(PW-NW){1'b0}}, n};
    rate = RW'(quo >> od);
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int RW = 16,
  parameter int NW = 5,
  parameter int MW = 9,
  parameter int ODW = 2,
  parameter int LOCK_POLLS = 24_000_000,
  parameter logic [NW-1:0]  RST_N  = 1,
  parameter logic [MW-1:0]  RST_M  = 20,
  parameter logic [ODW-1:0] RST_OD = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RW-1:0]     req_rate,
  input  logic [RW-1:0]     parent_rate,
  input  logic              hit,
  input  logic [NW-1:0]     hit_n,
  input  logic [MW-1:0]     hit_m,
  input  logic [ODW-1:0]    hit_od,
  input  logic              pll_lock,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic [NW-1:0]     cur_n,
  output logic [MW-1:0]     cur_m,
  output logic [ODW-1:0]    cur_od,
  output logic              done,
  output logic [1:0]        status
);
  localparam int PCW = (LOCK_POLLS > 1) ? $clog2(LOCK_POLLS) : 1;
  localparam logic [PCW-1:0] POLL_LAST = PCW'(LOCK_POLLS - 1);

  seq_state_e     state;
  logic [NW-1:0]  tgt_n, prv_n;
  logic [MW-1:0]  tgt_m, prv_m;
  logic [ODW-1:0] tgt_od, prv_od;
  logic           restoring;
  logic [PCW-1:0] poll_cnt;
  logic [1:0]     status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tgt_n     <= RST_N;   prv_n  <= RST_N;   cur_n  <= RST_N;
      tgt_m     <= RST_M;   prv_m  <= RST_M;   cur_m  <= RST_M;
      tgt_od    <= RST_OD;  prv_od <= RST_OD;  cur_od <= RST_OD;
      restoring <= 1'b0;
      poll_cnt  <= '0;
      status_q  <= STAT_OK;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          if (parent_rate == '0 || req_rate == '0 || !hit) begin
            status_q <= STAT_INVALID;
            state    <= S_FIN;
          end else begin
            tgt_n     <= hit_n;  tgt_m <= hit_m;  tgt_od <= hit_od;
            prv_n     <= cur_n;  prv_m <= cur_m;  prv_od <= cur_od;
            restoring <= 1'b0;
            state     <= S_RST;
          end
        end
        S_RST: state <= S_N;
        S_N: begin
          cur_n <= tgt_n;
          state <= S_M;
        end
        S_M: begin
          cur_m <= tgt_m;
          state <= S_OD;
        end
        S_OD: begin
          cur_od   <= tgt_od;
          poll_cnt <= '0;
          state    <= S_POLL;
        end
        S_POLL: begin
          if (pll_lock) begin
            status_q <= restoring ? STAT_TIMEOUT : STAT_OK;
            state    <= S_FIN;
          end else if (poll_cnt == POLL_LAST) begin
            if (restoring) begin
              status_q <= STAT_TIMEOUT;
              state    <= S_FIN;
            end else begin
              restoring <= 1'b1;
              tgt_n     <= prv_n;  tgt_m <= prv_m;  tgt_od <= prv_od;
              state     <= S_RST;
            end
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == S_IDLE);
    done      = (state == S_FIN);
    status    = status_q;
    wr_en     = 1'b0;
    wr_sel    = SEL_N;
    wr_data   = '0;
    case (state)
      S_RST: begin
        wr_en              = 1'b1;
        wr_data[NW-1:0]    = cur_n;
        wr_data[RST_BIT]   = 1'b1;
      end
      S_N: begin
        wr_en           = 1'b1;
        wr_data[NW-1:0] = tgt_n;
      end
      S_M: begin
        wr_en           = 1'b1;
        wr_sel          = SEL_M;
        wr_data[MW-1:0] = tgt_m;
      end
      S_OD: begin
        wr_en            = 1'b1;
        wr_sel           = SEL_OD;
        wr_data[ODW-1:0] = tgt_od;
      end
      default: ;
    endcase
  end

  // R4
  rst_then_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_N && wr_data[RST_BIT]) |=>
    (wr_en && wr_sel == SEL_N && !wr_data[RST_BIT]));
  // R4
  n_then_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_N && !wr_data[RST_BIT]) |=> (wr_en && wr_sel == SEL_M));
  // R4
  m_then_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_M) |=> (wr_en && wr_sel == SEL_OD));
  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> (poll_cnt <= POLL_LAST));
  // R6
  timeout_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL && !pll_lock && poll_cnt == POLL_LAST && !restoring) |=>
    (wr_en && wr_sel == SEL_N && wr_data[RST_BIT]));
  // R2
  zero_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (parent_rate == '0 || req_rate == '0)) |=>
    (done && status == STAT_INVALID && !wr_en));
  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'b11));
  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int RW = 16,
  parameter int NW = 5,
  parameter int MW = 9,
  parameter int ODW = 2,
  parameter int DEPTH = 4,
  parameter int TBL_COUNT = 4,
  parameter int LOCK_POLLS = 24_000_000,
  parameter logic [NW-1:0]  RST_N  = 1,
  parameter logic [MW-1:0]  RST_M  = 20,
  parameter logic [ODW-1:0] RST_OD = 0,
  parameter logic [DEPTH*RW-1:0]  TBL_RATE = {16'd1200, 16'd1008, 16'd900, 16'd600},
  parameter logic [DEPTH*NW-1:0]  TBL_N    = {5'd1, 5'd2, 5'd1, 5'd1},
  parameter logic [DEPTH*MW-1:0]  TBL_M    = {9'd50, 9'd84, 9'd75, 9'd50},
  parameter logic [DEPTH*ODW-1:0] TBL_OD   = {2'd0, 2'd0, 2'd1, 2'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RW-1:0]     req_rate,
  input  logic [RW-1:0]     parent_rate,
  output logic              done,
  output logic [1:0]        status,
  input  logic [RW-1:0]     rnd_req,
  output logic [RW-1:0]     rnd_rate,
  output logic              rnd_ok,
  output logic [RW-1:0]     cur_rate,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [DATA_W-1:0] wr_data,
  input  logic              pll_lock
);
  logic           hit;
  logic [NW-1:0]  hit_n, cur_n;
  logic [MW-1:0]  hit_m, cur_m;
  logic [ODW-1:0] hit_od, cur_od;

  pll_rate_lookup #(
    .RW(RW), .NW(NW), .MW(MW), .ODW(ODW), .DEPTH(DEPTH), .COUNT(TBL_COUNT),
    .TBL_RATE(TBL_RATE), .TBL_N(TBL_N), .TBL_M(TBL_M), .TBL_OD(TBL_OD)
  ) lookup_i (
    .set_rate(req_rate), .hit(hit), .hit_n(hit_n), .hit_m(hit_m), .hit_od(hit_od),
    .rnd_req(rnd_req), .rnd_rate(rnd_rate), .rnd_ok(rnd_ok)
  );

  pll_seq_fsm #(
    .RW(RW), .NW(NW), .MW(MW), .ODW(ODW), .LOCK_POLLS(LOCK_POLLS),
    .RST_N(RST_N), .RST_M(RST_M), .RST_OD(RST_OD)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rate(req_rate), .parent_rate(parent_rate),
    .hit(hit), .hit_n(hit_n), .hit_m(hit_m), .hit_od(hit_od), .pll_lock(pll_lock),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_n(cur_n), .cur_m(cur_m), .cur_od(cur_od),
    .done(done), .status(status)
  );

  pll_rate_calc #(.RW(RW), .NW(NW), .MW(MW), .ODW(ODW)) calc_i (
    .parent_rate(parent_rate), .n(cur_n), .m(cur_m), .od(cur_od), .rate(cur_rate)
  );
endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, ro_valid = 1'b0;
  logic        req_ready, ro_ready;
  logic [15:0] req_rate = '0, parent_rate = 16'd24, rnd_req = '0;
  logic        done, ro_done;
  logic [1:0]  status, ro_status;
  logic [15:0] rnd_rate, ro_rnd_rate, cur_rate, ro_cur_rate;
  logic        rnd_ok, ro_rnd_ok;
  logic        wr_en, ro_wr_en;
  logic [1:0]  wr_sel, ro_wr_sel;
  logic [31:0] wr_data, ro_wr_data;
  logic        pll_lock = 1'b1;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_reprog_seq #(.LOCK_POLLS(POLLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rate(req_rate), .parent_rate(parent_rate), .done(done), .status(status),
    .rnd_req(rnd_req), .rnd_rate(rnd_rate), .rnd_ok(rnd_ok), .cur_rate(cur_rate),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pll_lock(pll_lock));

  pll_reprog_seq #(.LOCK_POLLS(POLLS), .TBL_COUNT(0)) dut_ro_i (
    .clk(clk), .rst_n(rst_n), .req_valid(ro_valid), .req_ready(ro_ready),
    .req_rate(req_rate), .parent_rate(parent_rate), .done(ro_done), .status(ro_status),
    .rnd_req(rnd_req), .rnd_rate(ro_rnd_rate), .rnd_ok(ro_rnd_ok), .cur_rate(ro_cur_rate),
    .wr_en(ro_wr_en), .wr_sel(ro_wr_sel), .wr_data(ro_wr_data), .pll_lock(1'b1));

  // behavioural PLL model and write log
  int          cyc = 0, log_cnt = 0, ro_writes = 0, lcnt = 0, lock_dly = 2;
  bit          armed = 0, fail_mode = 0;
  int          log_sel [1024];
  logic [31:0] log_dat [1024];
  int          log_cyc [1024];
  int          m_n = 1, m_m = 20, m_od = 0;

  always @(negedge clk) begin
    cyc++;
    if (wr_en) begin
      log_sel[log_cnt] = int'(wr_sel);
      log_dat[log_cnt] = wr_data;
      log_cyc[log_cnt] = cyc;
      if (log_cnt < 1023) log_cnt++;
      case (wr_sel)
        2'd0: begin
          m_n = int'(wr_data[4:0]);
          if (wr_data[29]) begin pll_lock = 1'b0; armed = 0; end
        end
        2'd1: m_m = int'(wr_data[8:0]);
        default: begin m_od = int'(wr_data[1:0]); armed = 1; lcnt = 0; end
      endcase
    end else if (armed && !fail_mode) begin
      lcnt++;
      if (lcnt >= lock_dly) begin pll_lock = 1'b1; armed = 0; end
    end
    if (ro_wr_en) ro_writes++;
  end

  function automatic int tb_rate(int i);
    case (i) 0: return 600; 1: return 900; 2: return 1008; default: return 1200; endcase
  endfunction
  function automatic int tb_n(int i);
    case (i) 2: return 2; default: return 1; endcase
  endfunction
  function automatic int tb_m(int i);
    case (i) 0: return 50; 1: return 75; 2: return 84; default: return 50; endcase
  endfunction
  function automatic int tb_od(int i);
    case (i) 0: return 1; 1: return 1; default: return 0; endcase
  endfunction
  function automatic int find_exact(int r);
    for (int i = 0; i < 4; i++) if (tb_rate(i) == r) return i;
    return -1;
  endfunction
  function automatic int exp_round(int r);
    for (int i = 0; i < 4; i++) if (r <= tb_rate(i)) return tb_rate(i);
    return tb_rate(0);
  endfunction
  function automatic int exp_cur(int p, int n, int m, int od);
    if (n == 0) return 0;
    return (((p * m) / n) >> od) & 16'hFFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_wr(input int k, input int sel, input int dat, input string what);
    check(log_sel[k] == sel, "R4", {what, " sel"}, log_sel[k], sel);
    check(int'(log_dat[k]) == dat, "R4", {what, " data"}, int'(log_dat[k]), dat);
  endtask

  task automatic do_req(input int par, input int rate, input bit fail, input int dly);
    int log0, waitc, idx, pn, pm, pod, nw, st;
    while (!req_ready) @(negedge clk);
    parent_rate = 16'(par);
    fail_mode   = fail;
    lock_dly    = dly;
    log0 = log_cnt;
    pn = m_n; pm = m_m; pod = m_od;
    req_rate  = 16'(rate);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!done && waitc < 500) begin @(negedge clk); waitc++; end
    check(done == 1'b1, "R9", "done seen", int'(done), 1);
    idx = (par != 0 && rate != 0) ? find_exact(rate) : -1;
    nw  = log_cnt - log0;
    st  = int'(status);
    if (idx < 0) begin
      check(st == 1, rate == 0 || par == 0 ? "R2" : "R3", "status invalid", st, 1);
      check(nw == 0, rate == 0 || par == 0 ? "R2" : "R3", "no writes", nw, 0);
      check(waitc == 0, "R2", "done latency", waitc, 0);
    end else if (!fail) begin
      check(st == 0, "R5", "status ok", st, 0);
      check(nw == 4, "R4", "write count", nw, 4);
      check_wr(log0,   0, (1 << 29) | pn, "reset N");
      check_wr(log0+1, 0, tb_n(idx), "new N");
      check_wr(log0+2, 1, tb_m(idx), "new M");
      check_wr(log0+3, 2, tb_od(idx), "new OD");
      check(log_cyc[log0+3] == log_cyc[log0] + 3, "R4", "consecutive", log_cyc[log0+3] - log_cyc[log0], 3);
    end else begin
      check(st == 2, "R6", "status timeout", st, 2);
      check(nw == 8, "R6", "write count", nw, 8);
      check(log_cyc[log0+4] - log_cyc[log0+3] == POLLS + 1, "R5", "poll window",
            log_cyc[log0+4] - log_cyc[log0+3], POLLS + 1);
      check_wr(log0+4, 0, (1 << 29) | tb_n(idx), "restore reset N");
      check_wr(log0+5, 0, pn, "restore N");
      check_wr(log0+6, 1, pm, "restore M");
      check_wr(log0+7, 2, pod, "restore OD");
      check(m_n == pn && m_m == pm && m_od == pod, "R6", "fields restored", m_m, pm);
    end
    check(int'(cur_rate) == exp_cur(par, m_n, m_m, m_od), "R1", "cur_rate",
          int'(cur_rate), exp_cur(par, m_n, m_m, m_od));
    @(negedge clk);
    check(!done && req_ready, "R9", "pulse and ready", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R9 watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(req_ready && !done && !wr_en, "R9", "reset idle", int'(req_ready), 1);
    check(status == 2'd0, "R9", "reset status", int'(status), 0);
    check(int'(cur_rate) == 480, "R1", "reset cur_rate", int'(cur_rate), 480);

    // R7 rounding corners and random
    for (int k = 0; k < 30; k++) begin
      int r;
      case (k)
        0: r = 0; 1: r = 600; 2: r = 601; 3: r = 1008; 4: r = 1200; 5: r = 1201; 6: r = 65535;
        default: r = int'($urandom % 1400);
      endcase
      rnd_req = 16'(r);
      #1;
      check(rnd_ok && int'(rnd_rate) == exp_round(r), "R7", "round", int'(rnd_rate), exp_round(r));
    end
    @(negedge clk);

    // directed requests
    do_req(24, 900, 0, 1);
    do_req(24, 1008, 0, 4);
    do_req(24, 1200, 1, 1);
    do_req(0, 600, 0, 1);
    do_req(24, 0, 0, 1);
    do_req(24, 777, 0, 1);
    do_req(24, 600, 1, 2);

    // random mix
    for (int k = 0; k < 40; k++) begin
      int sel, par, rate;
      par = ($urandom % 8 == 0) ? 0 : 24;
      sel = int'($urandom % 10);
      if (sel < 6)       rate = tb_rate(int'($urandom % 4));
      else if (sel < 8)  rate = 1 + int'($urandom % 1500);
      else               rate = 0;
      do_req(par, rate, ($urandom % 4 == 0), 1 + int'($urandom % 5));
    end

    // R8 read-only instance
    parent_rate = 16'd24;
    rnd_req = 16'd700;
    while (!ro_ready) @(negedge clk);
    req_rate = 16'd600;
    ro_valid = 1'b1;
    @(negedge clk);
    ro_valid = 1'b0;
    check(ro_done && ro_status == 2'd1, "R8", "read-only reject", int'(ro_status), 1);
    check(ro_writes == 0, "R8", "read-only writes", ro_writes, 0);
    check(!ro_rnd_ok && ro_rnd_rate == 16'd0, "R8", "read-only round", int'(ro_rnd_rate), 0);
    check(int'(ro_cur_rate) == 480, "R8", "read-only cur_rate", int'(ro_cur_rate), 480);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule